// File: doc/BRIEF.md
# Prioritized Masked Interrupt Controller

The controller gathers interrupt request lines that arrive with no timing relation to the processor clock. Each line passes through a flip-flop synchronizer. A rising edge on a synchronized line is captured as a pending request, so a request that lasts only briefly is still kept. Requests from sources that software has disabled are discarded. The remaining pending requests are ranked by fixed priority, and the controller presents the winner to the processor as a one-hot select, a binary source number and a service-routine address.

The processor takes the winner with a one-cycle `ack`. That moves the source from pending to in service. While a source is in service, new edges on its line are dropped, and the source cannot win again. Software ends the service with a register write that frees the source. A build-time option selects the address scheme:

- one shared handler address, where software then finds the cause, or
- a separate address per source, spaced four bytes apart from a programmable base.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A request line that goes high is seen as `irq` after the third rising clock edge that follows. Two of these edges are the synchronizer stages and one is the edge capture. A high level that lasts at least one clock period stays pending after the line drops again.
- R2: After reset the enable mask is all zero. A source whose enable bit is 0 never drives `irq` or the select outputs. An edge that arrives while its source is disabled is lost. Clearing the enable bit of a pending source removes that request.
- R3: `grant_onehot` has at most one bit set. `grant_id` is the binary index of that bit. `irq` is high exactly when a grant exists.
- R4: When several sources are eligible at the same time, the one with the lowest index wins.
- R5: When PER_SOURCE is 1, `vec_addr` equals base + 4 × `grant_id`.
- R6: When PER_SOURCE is 0, `vec_addr` equals the base register at all times.
- R7: `ack` while `irq` is high marks the current winner in service and clears its pending bit. The next eligible source is presented after that clock edge.
- R8: While a source is in service, rising edges on its line are dropped, and the source is never granted.
- R9: A write with `cfg_addr` = 2 takes the source index from the low bits of `cfg_wdata` and ends that source's service. Later edges on that line are accepted again. An edge that was dropped during service does not reappear.
- R10: `cfg_addr` = 0 writes the enable mask, where bit i set to 1 enables source i. `cfg_addr` = 1 writes the vector base. Both take effect after the clock edge of the write. After reset the base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | processor clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_async | input | NUM_SRC | asynchronous request lines, one per source |
| cfg_we | input | 1 | configuration write strobe |
| cfg_addr | input | 2 | register select: 0 mask, 1 base, 2 end of service |
| cfg_wdata | input | ADDR_W | write data |
| ack | input | 1 | processor takes the current winner |
| irq | output | 1 | an eligible request exists |
| vec_addr | output | ADDR_W | service-routine address of the winner |
| grant_onehot | output | NUM_SRC | one-hot select of the winner |
| grant_id | output | ID_W | binary index of the winner |

## Verification
The checks on in-service capture assume two things. First, software never ends the service of the same source in the cycle where `ack` captures it. Second, `ack` is a single-cycle pulse. The stimulus keeps to both rules: every `ack` lasts one clock, and end-of-service writes occur only while `ack` is low. Request lines change only at falling edges and stay high for at least one full period, so the synchronizer sees each pulse. Two instances with opposite vector modes receive the same inputs, so the shared-address and per-source behaviour are compared under identical traffic.

// File: rtl/irq_prio_ctrl_pkg.sv
package irq_prio_ctrl_pkg;

   // register select codes on cfg_addr
   typedef enum logic [1:0] {
      SEL_MASK = 2'd0,
      SEL_BASE = 2'd1,
      SEL_DONE = 2'd2,
      SEL_RSVD = 2'd3
   } cfg_sel_e;

   // byte spacing of per-source vectors, as a shift amount
   localparam int unsigned VEC_SHIFT = 2;

   function automatic int unsigned id_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] rise_o
);

   logic [WIDTH-1:0] chain [STAGES];
   logic [WIDTH-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= '0;
         last_q <= '0;
      end else begin
         chain[0] <= async_in;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
         last_q <= chain[STAGES-1];
      end
   end

   assign rise_o = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/irq_fixed_arbiter.sv
module irq_fixed_arbiter #(
   parameter int unsigned N    = 8,
   parameter int unsigned ID_W = 3
) (
   input  logic [N-1:0]    elig,
   output logic [N-1:0]    grant,
   output logic [ID_W-1:0] grant_id,
   output logic            any
);

   logic seen;

   always_comb begin
      seen  = 1'b0;
      grant = '0;
      for (int i = 0; i < N; i++) begin
         grant[i] = elig[i] & ~seen;
         seen     = seen | elig[i];
      end
   end

   always_comb begin
      grant_id = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) grant_id = ID_W'(i);
      end
   end

   assign any = seen;

endmodule

// File: rtl/irq_vector_map.sv
module irq_vector_map
   import irq_prio_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned ID_W       = 3,
   parameter bit          PER_SOURCE = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ID_W-1:0]   id,
   output logic [ADDR_W-1:0] vec
);

   generate
      if (PER_SOURCE) begin : g_vectored
         assign vec = base + (ADDR_W'(id) << VEC_SHIFT);
      end else begin : g_common
         logic unused_id;
         assign unused_id = ^id;
         assign vec       = base;
      end
   endgenerate

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_ctrl_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 8,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PER_SOURCE  = 1'b1,
   localparam int unsigned ID_W       = id_width(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_async,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_addr,
   input  logic [ADDR_W-1:0]  cfg_wdata,
   input  logic               ack,
   output logic               irq,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic [NUM_SRC-1:0] grant_onehot,
   output logic [ID_W-1:0]    grant_id
);

   generate
      if (NUM_SRC < 1 || NUM_SRC > ADDR_W) begin : g_bad_src
         $error("NUM_SRC must lie in 1..ADDR_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < ID_W + VEC_SHIFT) begin : g_bad_addr
         $error("ADDR_W too narrow for the vector table");
      end
   endgenerate

   cfg_sel_e           sel;
   logic               wr_mask, wr_base, wr_done;
   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] mask_q, pend_q, insvc_q;
   logic [NUM_SRC-1:0] pend_d, insvc_d, elig;
   logic [ADDR_W-1:0]  base_q;
   logic               take;

   assign sel     = cfg_sel_e'(cfg_addr);
   assign wr_mask = cfg_we && (sel == SEL_MASK);
   assign wr_base = cfg_we && (sel == SEL_BASE);
   assign wr_done = cfg_we && (sel == SEL_DONE);

   irq_sync_edge #(
      .WIDTH  (NUM_SRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (req_async),
      .rise_o   (rise)
   );

   assign elig = pend_q & mask_q & ~insvc_q;

   irq_fixed_arbiter #(
      .N    (NUM_SRC),
      .ID_W (ID_W)
   ) u_arb (
      .elig     (elig),
      .grant    (grant_onehot),
      .grant_id (grant_id),
      .any      (irq)
   );

   irq_vector_map #(
      .ADDR_W     (ADDR_W),
      .ID_W       (ID_W),
      .PER_SOURCE (PER_SOURCE)
   ) u_vec (
      .base (base_q),
      .id   (grant_id),
      .vec  (vec_addr)
   );

   assign take = ack && irq;

   always_comb begin
      pend_d = (pend_q | (rise & ~insvc_q)) & mask_q;
      if (take) pend_d = pend_d & ~grant_onehot;
   end

   always_comb begin
      insvc_d = insvc_q;
      if (wr_done) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (cfg_wdata[ID_W-1:0] == ID_W'(i)) insvc_d[i] = 1'b0;
         end
      end
      if (take) insvc_d = insvc_d | grant_onehot;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         base_q  <= '0;
         pend_q  <= '0;
         insvc_q <= '0;
      end else begin
         pend_q  <= pend_d;
         insvc_q <= insvc_d;
         if (wr_mask) mask_q <= cfg_wdata[NUM_SRC-1:0];
         if (wr_base) base_q <= cfg_wdata;
      end
   end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int unsigned N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         irq,
   input logic         ack,
   input logic         done_wr,
   input logic [N-1:0] grant,
   input logic [N-1:0] mask_q,
   input logic [N-1:0] pend_q,
   input logic [N-1:0] insvc_q
);

   // R3
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R3
   irq_matches_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (grant != '0));

   // R2
   masked_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~mask_q) == '0);

   // R4
   lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |-> (((grant - 1'b1) & pend_q & mask_q & ~insvc_q) == '0));

   // R8
   insvc_not_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & insvc_q) == '0);

   // R7
   ack_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq && !done_wr) |=> ((insvc_q & $past(grant)) == $past(grant)));

   // R7
   ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq) |=> ((pend_q & $past(grant)) == '0));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N(NUM_SRC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq     (irq),
   .ack     (ack),
   .done_wr (wr_done),
   .grant   (grant_onehot),
   .mask_q  (mask_q),
   .pend_q  (pend_q),
   .insvc_q (insvc_q)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  req_async = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        ack = 1'b0;

   logic        irq_v, irq_c;
   logic [31:0] vec_v, vec_c;
   logic [7:0]  grant_v, grant_c;
   logic [2:0]  id_v, id_c;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   irq_prio_ctrl #(.NUM_SRC(8), .ADDR_W(32), .SYNC_STAGES(2), .PER_SOURCE(1'b1)) u_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .req_async(req_async), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ack(ack),
      .irq(irq_v), .vec_addr(vec_v), .grant_onehot(grant_v), .grant_id(id_v));

   irq_prio_ctrl #(.NUM_SRC(8), .ADDR_W(32), .SYNC_STAGES(2), .PER_SOURCE(1'b0)) u_irq_prio_ctrl_common (
      .clk(clk), .rst_n(rst_n), .req_async(req_async), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ack(ack),
      .irq(irq_c), .vec_addr(vec_c), .grant_onehot(grant_c), .grant_id(id_c));

   typedef struct {
      string       tag;
      logic        irq;
      logic [7:0]  grant;
      logic [2:0]  id;
      logic [31:0] vec;
      logic [31:0] cvec;
   } exp_t;

   exp_t exp_q[$];
   event sample_ev;

   // driver side: push expected item, wake the monitor
   task automatic expect_out(input string tag, input logic irq_e, input logic [7:0] g,
                             input logic [2:0] id, input logic [31:0] vec, input logic [31:0] cvec);
      exp_t item;
      item.tag = tag; item.irq = irq_e; item.grant = g;
      item.id = id; item.vec = vec; item.cvec = cvec;
      exp_q.push_back(item);
      ->sample_ev;
      #1;
   endtask

   // monitor side: pop and compare against both instances
   initial begin
      forever begin
         @(sample_ev);
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (irq_v !== e.irq || grant_v !== e.grant || id_v !== e.id || vec_v !== e.vec ||
                irq_c !== e.irq || grant_c !== e.grant || vec_c !== e.cvec) begin
               errors++;
               $display("FAIL %s: irq=%b/%b grant=%h id=%0d vec=%h cvec=%h, expected irq=%b grant=%h id=%0d vec=%h cvec=%h",
                        e.tag, irq_v, irq_c, grant_v, id_v, vec_v, vec_c,
                        e.irq, e.grant, e.id, e.vec, e.cvec);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      tick(1);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      tick(1);
      ack = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      expect_out("R10 reset state", 1'b0, 8'h00, 3'd0, 32'h0, 32'h0);

      // R2: all sources disabled after reset, edge is lost
      req_async[0] = 1'b1;
      tick(4);
      expect_out("R2 masked after reset", 1'b0, 8'h00, 3'd0, 32'h0, 32'h0);
      req_async[0] = 1'b0;
      tick(3);

      // R10: base and mask writes
      cfg_write(2'd1, 32'h0000_1000);
      cfg_write(2'd0, 32'h0000_00FF);
      expect_out("R2 lost edge stays lost, R10 base", 1'b0, 8'h00, 3'd0, 32'h1000, 32'h1000);

      // R1: latency of three edges
      req_async[3] = 1'b1;
      tick(2);
      expect_out("R1 not yet after two edges", 1'b0, 8'h00, 3'd0, 32'h1000, 32'h1000);
      tick(1);
      expect_out("R1 R5 R6 source 3 on third edge", 1'b1, 8'h08, 3'd3, 32'h100C, 32'h1000);

      // R4: lower index overtakes
      req_async[1] = 1'b1;
      tick(3);
      expect_out("R4 source 1 beats 3", 1'b1, 8'h02, 3'd1, 32'h1004, 32'h1000);
      req_async[1] = 1'b0;
      req_async[3] = 1'b0;
      tick(1);

      // R7: ack moves 1 into service, 3 presented next
      pulse_ack();
      expect_out("R7 next winner after ack", 1'b1, 8'h08, 3'd3, 32'h100C, 32'h1000);

      // R8: edge on in-service source dropped
      req_async[1] = 1'b1;
      tick(1);
      req_async[1] = 1'b0;
      tick(4);
      expect_out("R8 in-service edge dropped", 1'b1, 8'h08, 3'd3, 32'h100C, 32'h1000);

      pulse_ack();
      expect_out("R7 all taken", 1'b0, 8'h00, 3'd0, 32'h1000, 32'h1000);

      // R9: end of service for source 1
      cfg_write(2'd2, 32'd1);
      tick(2);
      expect_out("R9 dropped edge not revived", 1'b0, 8'h00, 3'd0, 32'h1000, 32'h1000);

      // R1: one-period pulse is kept
      req_async[1] = 1'b1;
      tick(1);
      req_async[1] = 1'b0;
      tick(2);
      expect_out("R1 R9 short pulse after release", 1'b1, 8'h02, 3'd1, 32'h1004, 32'h1000);

      // R2: disabling withdraws pending source 1
      cfg_write(2'd0, 32'h0000_00FD);
      expect_out("R2 R10 mask applies next cycle", 1'b0, 8'h00, 3'd0, 32'h1000, 32'h1000);
      cfg_write(2'd0, 32'h0000_00FF);
      expect_out("R2 withdrawn request gone", 1'b0, 8'h00, 3'd0, 32'h1000, 32'h1000);

      // R9: free source 3, then two simultaneous requests
      cfg_write(2'd2, 32'd3);
      req_async[7] = 1'b1;
      req_async[5] = 1'b1;
      tick(3);
      expect_out("R4 source 5 beats 7", 1'b1, 8'h20, 3'd5, 32'h1014, 32'h1000);
      pulse_ack();
      expect_out("R5 R7 source 7 next", 1'b1, 8'h80, 3'd7, 32'h101C, 32'h1000);
      pulse_ack();
      expect_out("R7 none left", 1'b0, 8'h00, 3'd0, 32'h1000, 32'h1000);
      req_async[7] = 1'b0;
      req_async[5] = 1'b0;
      cfg_write(2'd2, 32'd5);
      cfg_write(2'd2, 32'd7);

      // R10: base change moves vectors
      cfg_write(2'd1, 32'h0000_2000);
      req_async[0] = 1'b1;
      tick(3);
      expect_out("R5 R6 R10 source 0 new base", 1'b1, 8'h01, 3'd0, 32'h2000, 32'h2000);
      req_async[0] = 1'b0;
      req_async[3] = 1'b1;
      tick(3);
      expect_out("R3 R4 source 0 still wins", 1'b1, 8'h01, 3'd0, 32'h2000, 32'h2000);
      req_async[3] = 1'b0;

      tick(1);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: %0d items unchecked, expected 0", exp_q.size());
      end
      finish_run();
   end

endmodule